// File: doc/BRIEF.md
# Programmable Serial Test Pattern Generator

This block produces a one-bit serial stream for feeding a long shift-register test chain. A one-bit type input picks one of two pattern families. The pulse family places a single 1 in each period, so only one stage of the chain switches at a time. The run family sends a block of zeros and then a block of ones. A three-bit length code sets the period. Together, the type and the length code set how often each stage of the chain toggles. With a period of L, the pulse family gives 2/L and the run family gives 1/L. One code value has no supported length. It is reported as a bad configuration, and the stream is then held quiet.

The stream steps forward only on cycles where the active-low shift enable is low. On every other cycle the output holds its value. The configuration is captured while reset is high and then stays fixed for the whole run. The block builds two identical generator copies. One copy drives the chain. The other copy gives a downstream checker the stream it should expect at the far end.

Top module: `patgen_serial_src`

## Requirements
- R1: While `rst` is high at a clock edge, both `ser_out` and `ref_out` become 0 and the generator returns to phase 0 of its period.
- R2: After reset, a clock edge with `shift_en_n` = 1 leaves `ser_out` and `ref_out` unchanged. Only edges with `shift_en_n` = 0 advance the pattern by one bit.
- R3: `len_code` selects the period parameter L = `len_code` + 2. This gives codes 0,1,3,4,5,6,7 → L = 2,3,5,6,7,8,9.
- R4: With `pat_type` = 0, the n-th enabled shift after reset (n counted from 0) outputs 1 exactly when n mod L = L−1 and 0 otherwise. The period is L, with a single 1 in each period.
- R5: With `pat_type` = 1, the n-th enabled shift outputs 0 when n mod 2L < L and 1 otherwise. This gives L zeros, then L ones, with a period of 2L.
- R6: Length code 2 (binary 010) is unsupported. After a reset with that code, `cfg_bad` = 1 and `ser_out` stays 0 for the whole run. With any other code, `cfg_bad` = 0.
- R7: Changes on `pat_type` and `len_code` while `rst` is low have no effect. The stream keeps following the values captured at the last reset edge.
- R8: `ref_out` equals `ser_out` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the configuration |
| shift_en_n | input | 1 | Active-low step enable |
| pat_type | input | 1 | 0 = single-pulse pattern, 1 = zero-run/one-run pattern |
| len_code | input | CODE_W | Period code |
| ser_out | output | 1 | Serial stream to the test chain |
| ref_out | output | 1 | Expected stream for the downstream checker |
| cfg_bad | output | 1 | High when the captured length code is unsupported |

## Verification
The assertions assume `rst` is high on the first clock edges, so that the configuration registers and shift state hold defined values before any property becomes active. They also assume the configuration is only meaningful as sampled at reset. The stimulus keeps to this by opening every test with a two-cycle reset that holds the intended type and code. Type and code are changed only in the middle of a run, to show that such changes are ignored. The enable follows a pseudo-random pattern with forced idle stretches, so that holding and stepping are both exercised for every supported code, for both types, and for the unsupported code.

// File: rtl/patgen_pkg.sv
package patgen_pkg;
  typedef enum logic {PAT_PULSE = 1'b0, PAT_RUNS = 1'b1} pat_kind_e;

  localparam int SKIP_CODE = 2;
  localparam int LEN_OFFSET = 2;

  function automatic bit code_is_ok(int code);
    return code != SKIP_CODE;
  endfunction

  function automatic int period_len(int code);
    return code + LEN_OFFSET;
  endfunction
endpackage

// File: rtl/patgen_len_dec.sv
module patgen_len_dec #(
  parameter int CODE_W = 3,
  parameter int TAP_W  = 4
) (
  input  logic [CODE_W-1:0] code,
  output logic [TAP_W-1:0]  tap,
  output logic              valid
);
  // tap index = L - 1 = code + 1
  always_comb begin
    tap   = TAP_W'(patgen_pkg::period_len(int'(code)) - 1);
    valid = patgen_pkg::code_is_ok(int'(code));
  end
endmodule

// File: rtl/patgen_ring.sv
module patgen_ring #(
  parameter int MAX_LEN = 9,
  parameter int TAP_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_runs,
  input  logic             runs_q,
  input  logic [TAP_W-1:0] tap,
  input  logic             valid,
  input  logic             adv,
  output logic             bit_o
);
  logic [MAX_LEN-1:0] stage_q;
  logic [MAX_LEN-1:0] live_mask;
  logic               tap_bit;
  logic               feedback;

  always_comb begin
    tap_bit  = stage_q[tap];
    feedback = runs_q ? ~tap_bit : tap_bit;
    for (int i = 0; i < MAX_LEN; i++) begin
      live_mask[i] = (i <= int'(tap));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= {{(MAX_LEN-1){1'b0}}, ~init_runs};
      bit_o   <= 1'b0;
    end else if (adv) begin
      stage_q <= {stage_q[MAX_LEN-2:0], feedback};
      bit_o   <= valid & tap_bit;
    end
  end

  AST_SINGLE_ONE: assert property (@(posedge clk) disable iff (rst)
    (valid && !runs_q) |-> ($countones(stage_q & live_mask) == 1)); // R4

  AST_PULSE_NARROW: assert property (@(posedge clk) disable iff (rst)
    (valid && !runs_q && bit_o && adv) |=> !bit_o); // R4
endmodule

// File: rtl/patgen_serial_src.sv
module patgen_serial_src #(
  parameter int CODE_W     = 3,
  parameter int NUM_COPIES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en_n,
  input  logic              pat_type,
  input  logic [CODE_W-1:0] len_code,
  output logic              ser_out,
  output logic              ref_out,
  output logic              cfg_bad
);
  localparam int MAX_LEN = (1 << CODE_W) + 1;
  localparam int TAP_W   = $clog2(MAX_LEN);

  logic                  runs_q;
  logic [CODE_W-1:0]     code_q;
  logic [TAP_W-1:0]      tap;
  logic                  valid;
  logic [NUM_COPIES-1:0] copy_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      runs_q  <= pat_type;
      code_q  <= len_code;
      cfg_bad <= !patgen_pkg::code_is_ok(int'(len_code));
    end
  end

  patgen_len_dec #(.CODE_W(CODE_W), .TAP_W(TAP_W)) dec_i (
    .code  (code_q),
    .tap   (tap),
    .valid (valid)
  );

  for (genvar g = 0; g < NUM_COPIES; g++) begin : g_copy
    patgen_ring #(.MAX_LEN(MAX_LEN), .TAP_W(TAP_W)) ring_i (
      .clk       (clk),
      .rst       (rst),
      .init_runs (pat_type),
      .runs_q    (runs_q),
      .tap       (tap),
      .valid     (valid),
      .adv       (!shift_en_n),
      .bit_o     (copy_bit[g])
    );
  end

  assign ser_out = copy_bit[0];
  assign ref_out = copy_bit[NUM_COPIES-1];

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    shift_en_n |=> $stable(ser_out)); // R2

  AST_BAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |-> !ser_out); // R6

  AST_COPY_MATCH: assert property (@(posedge clk) disable iff (rst)
    ser_out == ref_out); // R8
endmodule

// File: tb/patgen_serial_src_tb.sv
module patgen_serial_src_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       shift_en_n = 1'b1;
  logic       pat_type = 1'b0;
  logic [2:0] len_code = 3'd0;
  logic       ser_out, ref_out, cfg_bad;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  // behavioural reference state
  int  m_k = 0, m_len = 2;
  bit  m_runs = 0, m_bad = 0, m_exp = 0;
  bit  in_r7 = 0;
  int  lfsr = 32'h1ACE;

  always #5 clk = ~clk;

  patgen_serial_src dut_i (
    .clk(clk), .rst(rst), .shift_en_n(shift_en_n), .pat_type(pat_type),
    .len_code(len_code), .ser_out(ser_out), .ref_out(ref_out), .cfg_bad(cfg_bad)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_k = 0; m_exp = 0; m_runs = pat_type;
      m_len = int'(len_code) + 2; m_bad = (len_code == 3'd2);
    end else if (!shift_en_n) begin
      if (m_bad) m_exp = 0;
      else if (m_runs) m_exp = (m_k >= m_len);
      else m_exp = (m_k == m_len - 1);
      m_k = (m_k + 1) % (m_runs ? 2 * m_len : m_len);
    end
  end

  task automatic check(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(bit was_rst, bit was_idle);
    string tag;
    if (was_rst) tag = "R1";
    else if (m_bad) tag = "R6";
    else if (in_r7) tag = "R7";
    else if (was_idle) tag = "R2";
    else tag = m_runs ? "R3+R5" : "R3+R4";
    check(tag, ser_out, m_exp);
    check("R8", ref_out, ser_out);
    if (!was_rst) check("R6", cfg_bad, m_bad);
  endtask

  task automatic step_cycle(bit en_n);
    bit was_rst;
    shift_en_n = en_n;
    was_rst = rst;
    @(posedge clk);
    @(negedge clk);
    compare_all(was_rst, en_n);
  endtask

  task automatic run_case(bit ty, logic [2:0] code, int cycles);
    @(negedge clk);
    rst = 1'b1; pat_type = ty; len_code = code; in_r7 = 0;
    step_cycle(1'b1);
    step_cycle(1'b0);
    rst = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      if (c == cycles / 2) begin
        pat_type = ~ty; len_code = code + 3'd3; in_r7 = 1;  // R7: ignored mid-run
      end
      step_cycle((c % 17 > 12) ? 1'b1 : lfsr[0] & lfsr[3]);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 2; t++) begin
      for (int c = 0; c < 8; c++) begin
        run_case(t[0], c[2:0], 70);
      end
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule